// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block is a single-slave SPI master for flash-style command sequences, controlled through a small 32-bit register bus. Software first places up to eight outgoing bytes in two 32-bit registers, using a fixed byte packing. It then writes one control word. That word sets how many bytes to send, how many bytes to receive, and a start bit. The engine pulls chip select low and shifts the outgoing bytes out in SPI mode 0. It then keeps clocking to collect the requested incoming bytes. When it finishes, it stores the received bytes back into the same two registers and drops its busy flag.

The send phase and the receive phase run under one start command, with no gap between them. The SPI clock comes from the bus clock through a programmable divider. While a command is running, the register contents are protected. A separate register bit lets software hold chip select low between commands.

Top module: `spi_xact_engine`

## Requirements
- R1: After reset the control word at offset 0x00 reads 0, the divider field reads 3 (offset 0x28 reads 0x00030000), chip select is high, and SCLK and MOSI are low.
- R2: The control word at 0x00 is laid out as follows: bits 3:0 are the send count, bits 7:4 are the receive count, bit 8 is start (it always reads 0), and bit 16 is busy. A write with bit 8 set while idle starts a command using the counts in that same write. Busy then reads 1 for exactly (send+receive)*8*(divider+2)+1 cycles.
- R3: Send bytes 0 to 3 come from offset 0x04: byte 0 in bits 7:0, byte 1 in 31:24, byte 2 in 23:16, byte 3 in 15:8. Send bytes 4 to 7 come from offset 0x08, little-endian. Only the first send-count bytes go out, in index order, MSB first.
- R4: The SPI timing is mode 0. SCLK idles low. MOSI is held steady across each rising edge, and MISO is sampled on each rising edge. MOSI is low throughout the receive phase. Chip select stays low without a break for (send+receive)*8*(divider+2) cycles, and exactly that many bits are clocked.
- R5: The divider sits in bits 27:16 of offset 0x28. One SCLK period is divider+2 bus cycles, and SCLK is high for floor((divider+2)/2) of them.
- R6: After a command with a non-zero receive count, received bytes 0 to 3 appear little-endian at 0x08 and bytes 4 to 7 appear little-endian at 0x04. Bytes that were not received read as zero. With a receive count of 0, both registers keep their values.
- R7: While busy, writes to offsets 0x00, 0x04, 0x08 and 0x28 are ignored, and that includes a second start.
- R8: Bit 0 at offset 0x38 reads back as written. While it is set, chip select is held low even when idle.
- R9: A send or receive count above 8 acts as 8, and the field still reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench aims at the byte packing. A swapped lane in the send or receive path shows up as MOSI bit streams that are out of order, or as received bytes stored in the wrong register. It runs odd and even divider values and the minimum divider. An off-by-one in the period or the duty split changes the measured busy length, the chip-select length and the count of SCLK-high cycles. A command whose receive count is 0 must leave the data registers untouched; a design that always writes back would overwrite them with zeros. A second start and other writes issued during a long command must be ignored; a design that lets them through would restart the command, lengthen busy, or change the stored registers. It also sends a count above 8, which must be treated as 8; a design that skips this clamp would clock the wrong number of bits.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;
  localparam int REG_W     = 32;
  localparam int MAX_BYTES = 8;
  localparam int VEC_W     = MAX_BYTES * 8;
  localparam int CNT_W     = 4;
  localparam int BIT_W     = $clog2(2 * VEC_W + 1);

  localparam logic [7:0] OFS_XFER = 8'h00;
  localparam logic [7:0] OFS_OPC  = 8'h04;
  localparam logic [7:0] OFS_DAT  = 8'h08;
  localparam logic [7:0] OFS_CFG  = 8'h28;
  localparam logic [7:0] OFS_CSEL = 8'h38;

  localparam int XF_START  = 8;
  localparam int XF_BUSY   = 16;
  localparam int CFG_DLSB  = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} xact_state_e;

  // Outgoing byte order on the wire: index 0 first, placed at the top.
  function automatic logic [VEC_W-1:0] tx_stream(input logic [REG_W-1:0] opc,
                                                 input logic [REG_W-1:0] dat);
    return {opc[7:0], opc[31:24], opc[23:16], opc[15:8],
            dat[7:0], dat[15:8], dat[23:16], dat[31:24]};
  endfunction

  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] c);
    return (c > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : c;
  endfunction
endpackage

// File: rtl/spi_xact_regs.sv
module spi_xact_regs
  import spi_xact_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DIV_W   = 12,
  parameter int unsigned DIV_RST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  input  logic              busy,
  input  logic              wb_valid,
  input  logic [VEC_W-1:0]  wb_vec,
  output logic [REG_W-1:0]  rdata,
  output logic              start,
  output logic [7:0]        start_cnt,
  output logic [REG_W-1:0]  opc_q,
  output logic [REG_W-1:0]  dat_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              csel_q
);
  localparam int CFG_PAD = REG_W - CFG_DLSB - DIV_W;

  logic [7:0]       cnt_q, cnt_d;
  logic [REG_W-1:0] opc_d, dat_d;
  logic [DIV_W-1:0] div_d;
  logic             csel_d;
  logic sel_xfer, sel_opc, sel_dat, sel_cfg, sel_csel, wr_ok;

  assign sel_xfer = (addr == ADDR_W'(OFS_XFER));
  assign sel_opc  = (addr == ADDR_W'(OFS_OPC));
  assign sel_dat  = (addr == ADDR_W'(OFS_DAT));
  assign sel_cfg  = (addr == ADDR_W'(OFS_CFG));
  assign sel_csel = (addr == ADDR_W'(OFS_CSEL));
  assign wr_ok    = we && !busy;

  assign start     = wr_ok && sel_xfer && wdata[XF_START];
  assign start_cnt = wdata[7:0];

  always_comb begin
    cnt_d  = cnt_q;
    opc_d  = opc_q;
    dat_d  = dat_q;
    div_d  = div_q;
    csel_d = csel_q;
    if (wr_ok && sel_xfer) cnt_d = wdata[7:0];
    if (wr_ok && sel_opc)  opc_d = wdata;
    if (wr_ok && sel_dat)  dat_d = wdata;
    if (wr_ok && sel_cfg)  div_d = wdata[CFG_DLSB +: DIV_W];
    if (we && sel_csel)    csel_d = wdata[0];
    if (wb_valid) begin
      dat_d = wb_vec[REG_W-1:0];
      opc_d = wb_vec[VEC_W-1:REG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      opc_q  <= '0;
      dat_q  <= '0;
      div_q  <= DIV_W'(DIV_RST);
      csel_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      opc_q  <= opc_d;
      dat_q  <= dat_d;
      div_q  <= div_d;
      csel_q <= csel_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_xfer) begin
      rdata[7:0]     = cnt_q;
      rdata[XF_BUSY] = busy;
    end
    if (sel_opc)  rdata = opc_q;
    if (sel_dat)  rdata = dat_q;
    if (sel_cfg)  rdata = {{CFG_PAD{1'b0}}, div_q, {CFG_DLSB{1'b0}}};
    if (sel_csel) rdata[0] = csel_q;
  end
endmodule

// File: rtl/spi_xact_clkgen.sv
module spi_xact_clkgen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);
  localparam int PW = DIV_W + 1;

  logic [PW-1:0] ratio, low_len, cnt_q, cnt_d;
  logic          sclk_d;

  assign ratio   = {1'b0, div} + PW'(2);
  assign low_len = ratio - (ratio >> 1);
  assign rise    = run && (cnt_q == low_len - PW'(1));
  assign fall    = run && (cnt_q == ratio - PW'(1));

  always_comb begin
    cnt_d  = cnt_q + PW'(1);
    sclk_d = sclk;
    if (rise) sclk_d = 1'b1;
    if (fall) begin
      sclk_d = 1'b0;
      cnt_d  = '0;
    end
    if (!run) begin
      sclk_d = 1'b0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sclk  <= sclk_d;
    end
  end
endmodule

// File: rtl/spi_xact_shifter.sv
module spi_xact_shifter
  import spi_xact_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       start_cnt,
  input  logic [REG_W-1:0] opc,
  input  logic [REG_W-1:0] dat,
  input  logic             rise,
  input  logic             fall,
  input  logic             miso,
  output logic             run,
  output logic             busy,
  output logic             mosi,
  output logic             wb_valid,
  output logic [VEC_W-1:0] wb_vec
);
  xact_state_e      st_q, st_d;
  logic [VEC_W-1:0] tx_sh_q, tx_sh_d, rx_vec_q, rx_vec_d;
  logic [BIT_W-1:0] idx_q, idx_d, txb_q, txb_d, tot_q, tot_d;
  logic             rxany_q, rxany_d;
  logic [CNT_W-1:0] txn, rxn;
  logic [CNT_W:0]   nsum;
  logic [5:0]       rx_idx;
  logic             in_tx;

  assign txn    = clamp_cnt(start_cnt[3:0]);
  assign rxn    = clamp_cnt(start_cnt[7:4]);
  assign nsum   = {1'b0, txn} + {1'b0, rxn};
  assign in_tx  = idx_q < txb_q;
  assign rx_idx = 6'(idx_q - txb_q);

  always_comb begin
    st_d     = st_q;
    tx_sh_d  = tx_sh_q;
    rx_vec_d = rx_vec_q;
    idx_d    = idx_q;
    txb_d    = txb_q;
    tot_d    = tot_q;
    rxany_d  = rxany_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        tx_sh_d  = tx_stream(opc, dat);
        rx_vec_d = '0;
        idx_d    = '0;
        txb_d    = BIT_W'({txn, 3'b000});
        tot_d    = BIT_W'({nsum, 3'b000});
        rxany_d  = (rxn != '0);
        st_d     = (nsum == '0) ? ST_DONE : ST_RUN;
      end
      ST_RUN: begin
        if (rise && !in_tx) rx_vec_d[{rx_idx[5:3], ~rx_idx[2:0]}] = miso;
        if (fall) begin
          if (idx_q == tot_q - BIT_W'(1)) st_d = ST_DONE;
          else begin
            idx_d   = idx_q + BIT_W'(1);
            tx_sh_d = {tx_sh_q[VEC_W-2:0], 1'b0};
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      tx_sh_q  <= '0;
      rx_vec_q <= '0;
      idx_q    <= '0;
      txb_q    <= '0;
      tot_q    <= '0;
      rxany_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      tx_sh_q  <= tx_sh_d;
      rx_vec_q <= rx_vec_d;
      idx_q    <= idx_d;
      txb_q    <= txb_d;
      tot_q    <= tot_d;
      rxany_q  <= rxany_d;
    end
  end

  assign run      = (st_q == ST_RUN);
  assign busy     = (st_q != ST_IDLE);
  assign mosi     = run && in_tx && tx_sh_q[VEC_W-1];
  assign wb_valid = (st_q == ST_DONE) && rxany_q;
  assign wb_vec   = rx_vec_q;
endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine
  import spi_xact_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DIV_W   = 12,
  parameter int unsigned DIV_RST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  logic             rst_meta, rst_n_i;
  logic             busy, run, start, wb_valid, rise, fall, csel_q;
  logic [7:0]       start_cnt;
  logic [REG_W-1:0] opc_q, dat_q;
  logic [DIV_W-1:0] div_q;
  logic [VEC_W-1:0] wb_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  spi_xact_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .busy(busy), .wb_valid(wb_valid), .wb_vec(wb_vec), .rdata(reg_rdata),
    .start(start), .start_cnt(start_cnt), .opc_q(opc_q), .dat_q(dat_q),
    .div_q(div_q), .csel_q(csel_q)
  );

  spi_xact_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n_i), .run(run), .div(div_q),
    .sclk(spi_sclk), .rise(rise), .fall(fall)
  );

  spi_xact_shifter u_shift (
    .clk(clk), .rst_n(rst_n_i), .start(start), .start_cnt(start_cnt),
    .opc(opc_q), .dat(dat_q), .rise(rise), .fall(fall), .miso(spi_miso),
    .run(run), .busy(busy), .mosi(spi_mosi), .wb_valid(wb_valid), .wb_vec(wb_vec)
  );

  assign spi_cs_n = !(run || csel_q);
endmodule

// File: rtl/spi_xact_checker.sv
module spi_xact_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk,
  input logic        mosi,
  input logic        cs_n,
  input logic        busy,
  input logic        start,
  input logic        wb_valid,
  input logic [31:0] opc_q,
  input logic [31:0] dat_q
);
  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> !cs_n); // R4
  AST_SCLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> busy); // R5
  AST_MOSI_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mosi); // R4
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy); // R2
  AST_OPC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && !wb_valid) |=> $stable(opc_q)); // R7
  AST_DAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && !wb_valid) |=> $stable(dat_q)); // R7
  AST_WB_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) wb_valid |=> !busy); // R6
endmodule

bind spi_xact_engine spi_xact_checker u_chk (
  .clk(clk), .rst_n(rst_n_i), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
  .busy(busy), .start(start), .wb_valid(wb_valid), .opc_q(opc_q), .dat_q(dat_q)
);

// File: tb/spi_xact_engine_tb_top.sv
module spi_xact_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_xact_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  typedef struct {
    logic [127:0] bits;
    int           nbits;
    int           dur;
    int           hi;
  } exp_t;
  exp_t sbq[$];

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model: MISO changes after each falling SCLK edge
  logic [127:0] slv_pat = '0;
  int           s_cnt = 0;
  always @(negedge spi_sclk or posedge spi_cs_n)
    if (spi_cs_n) s_cnt <= 0;
    else          s_cnt <= s_cnt + 1;
  assign spi_miso = (spi_cs_n || s_cnt > 127) ? 1'b0 : slv_pat[7'(127 - s_cnt)];

  // MOSI capture on rising SCLK, cleared when chip select falls
  logic [127:0] mlog = '0;
  int           mcnt = 0;
  always @(posedge spi_sclk or negedge spi_cs_n)
    if (!spi_sclk) begin
      mlog <= '0;
      mcnt <= 0;
    end else begin
      mlog <= {mlog[126:0], spi_mosi};
      mcnt <= mcnt + 1;
    end

  // monitor: pops one expected item per chip-select window
  initial begin
    forever begin
      int n;
      int hi;
      @(negedge spi_cs_n);
      n = 0;
      hi = 0;
      forever begin
        @(negedge clk);
        if (spi_cs_n) break;
        n++;
        if (spi_sclk) hi++;
      end
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        chk("R3 mosi stream", mlog, e.bits);
        chk("R4 clocked bits", 128'(mcnt), 128'(e.nbits));
        chk("R4 cs low cycles", 128'(n), 128'(e.dur));
        chk("R5 sclk high cycles", 128'(hi), 128'(e.hi));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_xact(input int tx, input int rx, input int div,
                          input logic [31:0] opc, input logic [31:0] dat,
                          input logic [63:0] rxs, input bit meddle);
    int txn, rxn, t, nclk, nb;
    logic [63:0] ones, txs, rxm;
    logic [31:0] v, opc_e, dat_e;
    exp_t e;
    txn  = (tx > 8) ? 8 : tx;
    rxn  = (rx > 8) ? 8 : rx;
    t    = (txn + rxn) * 8;
    nclk = div + 2;
    ones = '1;
    wr(8'h28, 32'(div) << 16);
    wr(8'h04, opc);
    wr(8'h08, dat);
    slv_pat = {rxs, 64'b0} >> (txn * 8);
    txs = {opc[7:0], opc[31:24], opc[23:16], opc[15:8],
           dat[7:0], dat[15:8], dat[23:16], dat[31:24]};
    txs = txs & ~(ones >> (txn * 8));
    e.bits  = {txs, 64'b0} >> (128 - t);
    e.nbits = t;
    e.dur   = t * nclk;
    e.hi    = t * (nclk / 2);
    sbq.push_back(e);
    wr(8'h00, 32'h100 | 32'((rx << 4) | tx));
    nb = 0;
    if (meddle) begin
      wr(8'h04, 32'hDEAD_BEEF);
      wr(8'h08, 32'hCAFE_F00D);
      wr(8'h28, 32'h0001_0000);
      wr(8'h00, 32'h0000_0111);
      nb = 8;
    end
    forever begin
      rd(8'h00, v);
      if (!v[16]) break;
      nb++;
      @(negedge clk);
    end
    chk("R2 busy cycles", 128'(nb), 128'(t * nclk + 1));
    rxm = rxs & ~(ones >> (rxn * 8));
    if (rxn == 0) begin
      opc_e = opc;
      dat_e = dat;
    end else begin
      dat_e = {rxm[39:32], rxm[47:40], rxm[55:48], rxm[63:56]};
      opc_e = {rxm[7:0], rxm[15:8], rxm[23:16], rxm[31:24]};
    end
    rd(8'h04, v);
    chk(meddle ? "R7 opcode reg after busy writes" : "R6 opcode reg", 128'(v), 128'(opc_e));
    rd(8'h08, v);
    chk(meddle ? "R7 data reg after busy writes" : "R6 data reg", 128'(v), 128'(dat_e));
    rd(8'h00, v);
    chk("R9 count field readback", 128'(v), 128'((rx << 4) | tx));
    rd(8'h28, v);
    chk("R7 divider kept", 128'(v), 128'(32'(div) << 16));
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(8'h00, v); chk("R1 control word", 128'(v), 128'(0));
    rd(8'h28, v); chk("R1 divider reset", 128'(v), 128'(32'h0003_0000));
    chk("R1 cs_n idle", 128'(spi_cs_n), 128'(1));
    chk("R1 sclk idle", 128'(spi_sclk), 128'(0));
    chk("R1 mosi idle", 128'(spi_mosi), 128'(0));

    run_xact(1, 0, 3, 32'h1122_33A5, 32'h5566_7788, 64'h0, 1'b0);
    run_xact(4, 4, 0, 32'h0F1E_2D3C, 32'h0, 64'hA1B2_C3D4_0000_0000, 1'b0);
    run_xact(8, 8, 1, 32'h8091_A2B3, 32'hC4D5_E6F7, 64'h0123_4567_89AB_CDEF, 1'b0);
    run_xact(2, 3, 5, 32'hFF00_00C3, 32'h1234_5678, 64'h5A3C_E100_0000_0000, 1'b0);
    run_xact(12, 0, 10, 32'h6699_AA55, 32'h0102_0304, 64'h0, 1'b1);

    wr(8'h38, 32'h1);
    rd(8'h38, v); chk("R8 csel readback", 128'(v), 128'(1));
    chk("R8 cs_n forced low", 128'(spi_cs_n), 128'(0));
    chk("R8 sclk stays low", 128'(spi_sclk), 128'(0));
    wr(8'h38, 32'h0);
    chk("R8 cs_n released", 128'(spi_cs_n), 128'(1));

    repeat (4) @(negedge clk);
    chk("R4 scoreboard drained", 128'(sbq.size()), 128'(0));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule